// File: doc/BRIEF.md
# Dual ADC Synchronization Controller

This block coordinates two analog-to-digital conversion engines, called unit A and unit B, from one clock domain. It receives trigger pulses, a mode selection and, from each engine, a done strobe with a 16-bit result. It sends single-cycle start pulses to each engine. It packs the two results into one 32-bit word with a single-cycle DMA request. It also keeps a sticky end-of-conversion flag with a maskable interrupt.

The block has three modes. In independent mode, each trigger starts only its own engine, and each result updates only its own half of the word. In simultaneous mode, the unit A trigger starts both engines in the same cycle, and the round completes only when both have reported. In staggered mode, the unit A trigger starts unit B at once and unit A a fixed number of cycles later. This suits two engines that sample the same channel. With continuous operation enabled, staggered rounds restart by themselves. The analog engines, the register interface, sampling times and channel sequences sit outside this block.

Top module: `dual_adc_sync`

## Requirements
- R1: While and directly after reset, start_a, start_b, eoc_flag, eoc_irq and dma_req are 0 and pack_word is 0.
- R2: Independent mode (mode_sel 2'b00, and 2'b11 behaves the same): trig_a gives a start_a pulse in the next cycle and trig_b gives a start_b pulse in the next cycle; neither trigger starts the other unit.
- R3: In independent mode, done_a writes res_a into pack_word[15:0] and done_b writes res_b into pack_word[31:16], each leaving the other half unchanged; each such update sets eoc_flag.
- R4: Simultaneous mode (mode_sel 2'b01): trig_a starts both units in the same cycle, and trig_b has no effect on starting.
- R5: In simultaneous and staggered modes, a round completes only after both units have reported done; then pack_word becomes {unit B result, unit A result} and eoc_flag is set. Nothing is published while only one unit has reported.
- R6: Staggered mode (mode_sel 2'b10): trig_a gives start_b in the next cycle, and start_a follows exactly STAGGER_CYC cycles (default 7) after start_b.
- R7: In simultaneous and staggered modes, a trig_a that arrives while a round is pending is ignored.
- R8: In staggered mode with cont_en high, a completed round issues a new start_b in the cycle after completion, without a trigger, and the rounds keep repeating.
- R9: eoc_flag stays set until eoc_clr is high; a set in the same cycle as a clear wins.
- R10: eoc_irq is high only when eoc_flag and irq_en are both high.
- R11: dma_req is a single-cycle pulse in the cycle pack_word takes its new value; pack_word never changes without dma_req.
- R12: A change of mode_sel aborts any pending round: its later done strobes publish nothing, and a new trigger in the new mode is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | 00 independent, 01 simultaneous, 10 staggered, 11 independent |
| cont_en | input | 1 | Restart staggered rounds on completion |
| irq_en | input | 1 | End-of-conversion interrupt enable |
| trig_a | input | 1 | Trigger for unit A (and the pair in joint modes) |
| trig_b | input | 1 | Trigger for unit B, used in independent mode only |
| done_a | input | 1 | Unit A conversion done strobe |
| res_a | input | 16 | Unit A result, valid with done_a |
| done_b | input | 1 | Unit B conversion done strobe |
| res_b | input | 16 | Unit B result, valid with done_b |
| eoc_clr | input | 1 | Clear for the end-of-conversion flag |
| start_a | output | 1 | Start pulse to unit A |
| start_b | output | 1 | Start pulse to unit B |
| eoc_flag | output | 1 | Sticky end-of-conversion flag |
| eoc_irq | output | 1 | Masked end-of-conversion interrupt |
| pack_word | output | 32 | {unit B result, unit A result} |
| dma_req | output | 1 | One-cycle transfer request for pack_word |

## Verification
The properties assume that each engine gives at most one done strobe per start, and only after that start. They also assume that, in joint modes, no done strobe arrives while no round is pending, except for late strobes from an aborted round. The stagger-gap property further assumes that STAGGER_CYC stays below 255. The bench keeps its engine models within these limits. Each model answers a start after a latency of 1 to 15 cycles that is fixed at start time. The bench waits for a round to publish before it triggers again, and when it aborts a round it lets the stale strobes drain before it checks anything.

// File: rtl/dadc_pkg.sv
package dadc_pkg;

    parameter int unsigned DADC_RES_W  = 16;
    localparam int unsigned DADC_WORD_W = 2 * DADC_RES_W;

    typedef enum logic [1:0] {
        MODE_INDEP = 2'b00,
        MODE_SIMUL = 2'b01,
        MODE_STAGR = 2'b10,
        MODE_RSVD  = 2'b11
    } dadc_mode_e;

    typedef logic [DADC_RES_W-1:0] dadc_res_t;

    typedef struct packed {
        dadc_res_t hi;   // unit B
        dadc_res_t lo;   // unit A
    } dadc_word_t;

    function automatic logic mode_is_joint(input dadc_mode_e m);
        return (m == MODE_SIMUL) || (m == MODE_STAGR);
    endfunction

endpackage

// File: rtl/dadc_stagger_timer.sv
module dadc_stagger_timer #(
    parameter int unsigned DELAY = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic abort,
    output logic fire
);
    localparam int unsigned CW = $clog2(DELAY + 1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            remain <= '0;
        end else if (load) begin
            remain <= CW'(DELAY);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    // fire one cycle before the count runs out; the start register adds the last cycle
    assign fire = (remain == CW'(1)) && !abort;

endmodule

// File: rtl/dadc_pair_join.sv
module dadc_pair_join
    import dadc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       done_a,
    input  dadc_res_t  res_a,
    input  logic       done_b,
    input  dadc_res_t  res_b,
    output logic       both,
    output dadc_word_t word
);
    logic      got_a, got_b;
    dadc_res_t hold_a, hold_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            got_a  <= 1'b0;
            got_b  <= 1'b0;
            hold_a <= '0;
            hold_b <= '0;
        end else begin
            if (done_a) hold_a <= res_a;
            if (done_b) hold_b <= res_b;
            if (clear) begin
                got_a <= 1'b0;
                got_b <= 1'b0;
            end else begin
                got_a <= got_a | done_a;
                got_b <= got_b | done_b;
            end
        end
    end

    assign both    = (got_a | done_a) & (got_b | done_b);
    assign word.lo = done_a ? res_a : hold_a;
    assign word.hi = done_b ? res_b : hold_b;

endmodule

// File: rtl/dadc_eoc_flag.sv
module dadc_eoc_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    input  logic irq_en,
    output logic flag,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst)      flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

    assign irq = flag & irq_en;

endmodule

// File: rtl/dual_adc_sync.sv
module dual_adc_sync
    import dadc_pkg::*;
#(
    parameter int unsigned STAGGER_CYC = 7
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [1:0]             mode_sel,
    input  logic                   cont_en,
    input  logic                   irq_en,
    input  logic                   trig_a,
    input  logic                   trig_b,
    input  logic                   done_a,
    input  logic [DADC_RES_W-1:0]  res_a,
    input  logic                   done_b,
    input  logic [DADC_RES_W-1:0]  res_b,
    input  logic                   eoc_clr,
    output logic                   start_a,
    output logic                   start_b,
    output logic                   eoc_flag,
    output logic                   eoc_irq,
    output logic [DADC_WORD_W-1:0] pack_word,
    output logic                   dma_req
);
    dadc_mode_e mode, mode_q;
    logic       abort, joint, busy;
    logic       go, round_done, restart, fire;
    logic       join_both, join_clear, upd;
    dadc_word_t join_word, word_q, word_n;

    assign mode  = dadc_mode_e'(mode_sel);
    assign abort = (mode != mode_q);
    assign joint = mode_is_joint(mode);

    assign go         = joint && !abort && !busy && trig_a;
    assign round_done = joint && !abort && busy && join_both;
    assign restart    = round_done && (mode == MODE_STAGR) && cont_en;
    assign join_clear = abort || !busy || round_done;

    dadc_stagger_timer #(.DELAY(STAGGER_CYC)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .load  ((go || restart) && (mode == MODE_STAGR)),
        .abort (abort),
        .fire  (fire)
    );

    dadc_pair_join u_join (
        .clk    (clk),
        .rst    (rst),
        .clear  (join_clear),
        .done_a (done_a),
        .res_a  (res_a),
        .done_b (done_b),
        .res_b  (res_b),
        .both   (join_both),
        .word   (join_word)
    );

    always_comb begin
        word_n = word_q;
        upd    = 1'b0;
        if (!abort) begin
            if (joint) begin
                if (round_done) begin
                    word_n = join_word;
                    upd    = 1'b1;
                end
            end else if (done_a || done_b) begin
                if (done_a) word_n.lo = res_a;
                if (done_b) word_n.hi = res_b;
                upd = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= MODE_INDEP;
            busy    <= 1'b0;
            start_a <= 1'b0;
            start_b <= 1'b0;
            word_q  <= '0;
            dma_req <= 1'b0;
        end else begin
            mode_q  <= mode;
            word_q  <= word_n;
            dma_req <= upd;
            if (abort) begin
                busy    <= 1'b0;
                start_a <= 1'b0;
                start_b <= 1'b0;
            end else if (!joint) begin
                busy    <= 1'b0;
                start_a <= trig_a;
                start_b <= trig_b;
            end else begin
                if (go)              busy <= 1'b1;
                else if (round_done) busy <= restart;
                start_b <= go || restart;
                start_a <= (mode == MODE_SIMUL) ? go : fire;
            end
        end
    end

    assign pack_word = word_q;

    dadc_eoc_flag u_eoc (
        .clk    (clk),
        .rst    (rst),
        .set    (upd),
        .clr    (eoc_clr),
        .irq_en (irq_en),
        .flag   (eoc_flag),
        .irq    (eoc_irq)
    );

endmodule

// File: rtl/dadc_sync_checks.sv
module dadc_sync_checks
    import dadc_pkg::*;
#(
    parameter int unsigned OFFSET = 7
) (
    input logic                   clk,
    input logic                   rst,
    input logic [1:0]             mode_sel,
    input logic                   eoc_clr,
    input logic                   irq_en,
    input logic                   start_a,
    input logic                   start_b,
    input logic                   eoc_flag,
    input logic                   eoc_irq,
    input logic                   dma_req,
    input logic [DADC_WORD_W-1:0] pack_word
);
    logic [7:0] gap;

    always_ff @(posedge clk) begin
        if (rst)                          gap <= '0;
        else if (start_b)                 gap <= 8'd1;
        else if (gap != '0 && gap != '1)  gap <= gap + 8'd1;
    end

    AST_EOC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (eoc_flag && !eoc_clr) |=> eoc_flag); // R9

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        eoc_irq |-> eoc_flag); // R10

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> !eoc_irq); // R10

    AST_WORD_WITH_DMA: assert property (@(posedge clk) disable iff (rst)
        !dma_req |-> $stable(pack_word)); // R11

    AST_SIMUL_TOGETHER: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_sel) == MODE_SIMUL && (start_a || start_b)) |-> (start_a && start_b)); // R4

    AST_STAGGER_GAP: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_sel) == MODE_STAGR && start_a) |-> (gap == 8'(OFFSET))); // R6

endmodule

bind dual_adc_sync dadc_sync_checks #(.OFFSET(STAGGER_CYC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode_sel  (mode_sel),
    .eoc_clr   (eoc_clr),
    .irq_en    (irq_en),
    .start_a   (start_a),
    .start_b   (start_b),
    .eoc_flag  (eoc_flag),
    .eoc_irq   (eoc_irq),
    .dma_req   (dma_req),
    .pack_word (pack_word)
);

// File: tb/sim_dual_adc_sync.sv
`timescale 1ns/1ps
module sim_dual_adc_sync;
    localparam int OFFSET = 7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode_sel = 2'b00;
    logic        cont_en = 1'b0, irq_en = 1'b0, trig_a = 1'b0, trig_b = 1'b0;
    logic        done_a = 1'b0, done_b = 1'b0, eoc_clr = 1'b0;
    logic [15:0] res_a = '0, res_b = '0;
    logic        start_a, start_b, eoc_flag, eoc_irq, dma_req;
    logic [31:0] pack_word;

    always #2.5 clk = ~clk;

    dual_adc_sync #(.STAGGER_CYC(OFFSET)) u0 (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .cont_en(cont_en), .irq_en(irq_en),
        .trig_a(trig_a), .trig_b(trig_b), .done_a(done_a), .res_a(res_a),
        .done_b(done_b), .res_b(res_b), .eoc_clr(eoc_clr),
        .start_a(start_a), .start_b(start_b), .eoc_flag(eoc_flag), .eoc_irq(eoc_irq),
        .pack_word(pack_word), .dma_req(dma_req)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    int cyc = 0, dma_n = 0, sa_n = 0, sb_n = 0, sa_cyc = 0, sb_cyc = 0;
    int cnt_a = 0, cnt_b = 0, lat_a = 3, lat_b = 5;
    logic [15:0] nxt_a = '0, nxt_b = '0;
    logic [31:0] last_pack = '0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // one cycle: observe outputs away from the edge, then step the engine models
    task automatic tick();
        @(negedge clk);
        cyc++;
        done_a = 1'b0;
        done_b = 1'b0;
        if (dma_req) begin dma_n++; last_pack = pack_word; end
        if (start_a) begin sa_n++; sa_cyc = cyc; end
        if (start_b) begin sb_n++; sb_cyc = cyc; end
        if (cnt_a > 0) begin
            cnt_a--;
            if (cnt_a == 0) begin done_a = 1'b1; res_a = nxt_a; end
        end
        if (cnt_b > 0) begin
            cnt_b--;
            if (cnt_b == 0) begin done_b = 1'b1; res_b = nxt_b; end
        end
        if (start_a) begin nxt_a = 16'($urandom); cnt_a = lat_a; end
        if (start_b) begin nxt_b = 16'($urandom); cnt_b = lat_b; end
    endtask

    task automatic pulse_a();
        trig_a = 1'b1; tick(); trig_a = 1'b0;
    endtask

    task automatic pulse_b();
        trig_b = 1'b1; tick(); trig_b = 1'b0;
    endtask

    task automatic wait_dma(input int maxc);
        int base;
        base = dma_n;
        for (int i = 0; i < maxc && dma_n == base; i++) tick();
    endtask

    task automatic set_mode(input logic [1:0] m);
        mode_sel = m; tick(); tick();
    endtask

    function automatic logic [31:0] packed_exp(input logic [15:0] b, input logic [15:0] a);
        return {b, a};
    endfunction

    initial begin
        int sa0, sb0, d0;
        logic [15:0] lo_keep;
        void'($urandom(32'd20240611));
        repeat (3) tick();
        check(start_a == 0 && start_b == 0 && dma_req == 0, "R1", "starts/dma in reset", {start_a, start_b, dma_req}, 0);
        rst = 1'b0;
        tick();
        check(eoc_flag == 0 && eoc_irq == 0, "R1", "eoc after reset", {eoc_flag, eoc_irq}, 0);
        check(pack_word == 0, "R1", "pack after reset", pack_word, 0);

        // independent mode
        lat_a = 3; lat_b = 5;
        pulse_a();
        check(start_a == 1 && start_b == 0, "R2", "trig_a in indep", {start_a, start_b}, 2'b10);
        wait_dma(20);
        check(last_pack == packed_exp(16'h0, res_a), "R3", "low half update", last_pack, packed_exp(16'h0, res_a));
        check(eoc_flag == 1, "R3", "eoc set by indep done", eoc_flag, 1);
        lo_keep = res_a;
        pulse_b();
        check(start_b == 1 && start_a == 0, "R2", "trig_b in indep", {start_a, start_b}, 2'b01);
        wait_dma(20);
        check(last_pack == packed_exp(res_b, lo_keep), "R3", "high half update", last_pack, packed_exp(res_b, lo_keep));

        // interrupt gating and sticky flag
        tick();
        check(eoc_flag == 1 && eoc_irq == 0, "R10", "irq masked", {eoc_flag, eoc_irq}, 2'b10);
        irq_en = 1'b1; tick();
        check(eoc_irq == 1, "R10", "irq enabled", eoc_irq, 1);
        repeat (3) tick();
        check(eoc_flag == 1, "R9", "flag sticky", eoc_flag, 1);
        eoc_clr = 1'b1; tick(); eoc_clr = 1'b0;
        check(eoc_flag == 0 && eoc_irq == 0, "R9", "flag cleared", {eoc_flag, eoc_irq}, 0);
        irq_en = 1'b0;

        // simultaneous mode
        set_mode(2'b01);
        sa0 = sa_n; sb0 = sb_n;
        pulse_b(); repeat (3) tick();
        check(sa_n == sa0 && sb_n == sb0, "R4", "trig_b ignored", sa_n + sb_n, sa0 + sb0);
        lat_a = 2; lat_b = 9; d0 = dma_n;
        pulse_a();
        check(start_a == 1 && start_b == 1, "R4", "both start together", {start_a, start_b}, 2'b11);
        repeat (4) tick();
        check(dma_n == d0 && eoc_flag == 0, "R5", "no publish with one done", dma_n - d0, 0);
        wait_dma(20);
        check(last_pack == packed_exp(res_b, res_a), "R5", "simul packed word", last_pack, packed_exp(res_b, res_a));
        tick();
        check(dma_req == 0, "R11", "dma single cycle", dma_req, 0);

        // retrigger while pending
        lat_a = 10; lat_b = 10; sa0 = sa_n;
        pulse_a(); repeat (3) tick(); pulse_a();
        wait_dma(30);
        check(sa_n - sa0 == 1, "R7", "pending trigger ignored", sa_n - sa0, 1);

        // staggered mode
        set_mode(2'b10);
        lat_a = 3; lat_b = 4;
        pulse_a();
        check(start_b == 1 && start_a == 0, "R6", "unit B starts first", {start_a, start_b}, 2'b01);
        wait_dma(40);
        check(sa_cyc - sb_cyc == OFFSET, "R6", "stagger gap", 32'(sa_cyc - sb_cyc), OFFSET);
        check(last_pack == packed_exp(res_b, res_a), "R5", "stagger packed word", last_pack, packed_exp(res_b, res_a));

        // continuous staggered rounds
        cont_en = 1'b1; d0 = dma_n; sb0 = sb_n;
        pulse_a();
        repeat (80) tick();
        check(dma_n - d0 >= 3, "R8", "repeated rounds", dma_n - d0, 3);
        check(sb_n - sb0 >= 3, "R8", "self restarts", sb_n - sb0, 3);
        cont_en = 1'b0;
        repeat (40) tick();

        // abort on mode change
        set_mode(2'b01);
        lat_a = 15; lat_b = 15; d0 = dma_n;
        pulse_a(); repeat (3) tick();
        mode_sel = 2'b10;
        repeat (20) tick();
        check(dma_n == d0, "R12", "aborted round silent", dma_n - d0, 0);
        lat_a = 3; lat_b = 3;
        pulse_a();
        check(start_b == 1, "R12", "new trigger accepted", start_b, 1);
        wait_dma(40);

        // random rounds in the joint modes
        for (int r = 0; r < 40; r++) begin
            logic [1:0] m;
            m = ($urandom % 2 == 0) ? 2'b01 : 2'b10;
            if (m != mode_sel) set_mode(m);
            lat_a = 1 + ($urandom % 12);
            lat_b = 1 + ($urandom % 12);
            pulse_a();
            wait_dma(60);
            check(last_pack == packed_exp(res_b, res_a), "R5", "random round word", last_pack, packed_exp(res_b, res_a));
            if (m == 2'b10)
                check(sa_cyc - sb_cyc == OFFSET, "R6", "random stagger gap", 32'(sa_cyc - sb_cyc), OFFSET);
            else
                check(sa_cyc == sb_cyc, "R4", "random simul start", 32'(sa_cyc), 32'(sb_cyc));
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule